// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects 32 level-sensitive hardware request lines and a 32-bit set of software requests, qualifies them with an enable mask, and routes each enabled source to one of two independent outputs: a fast-interrupt line and a normal-interrupt line. Normal interrupts are ranked through a bank of eight vector slots. Each slot binds one source number to a handler address. Enabled normal sources that no enabled slot claims share a single default handler address at the lowest priority.

A handler reads the vector-address register to learn where to jump. That read records the priority level being served, so until the matching acknowledge only strictly more urgent slots can raise the normal-interrupt line. Nested reads stack their levels. A write of any value to the same register acknowledges the most recent one. The block never clears a hardware request. Software requests are cleared only through the software-clear register.

Register access uses a plain synchronous bus with word addresses, a write strobe and a read strobe. Read data is registered and appears the cycle after the read strobe. The two interrupt outputs and the bus signals are plain level signals; there is no valid/ready stream at this block's edge, so no back-pressure rules apply.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `fiq_o` is high in the same cycle as any source whose enable bit and fast-select bit are both 1 and whose request (hardware or software) is 1. It is independent of `irq_o`, and both may be high together.
- R2: A source's request is the OR of its hardware line and its software bit. A source whose enable bit is 0 affects neither output nor the vector address.
- R3: Among enabled slots whose bound source has an enabled, normal, pending request, the lowest slot index wins. The vector-address read returns that slot's handler address.
- R4: Any winning slot beats the default vector. When the only pending normal sources are claimed by no enabled slot (a disabled slot does not claim), `irq_o` is high and the vector read returns the default handler address.
- R5: A vector-address read while `irq_o` is high records the served level (slot index, or the default level below all slots). Until it is acknowledged, `irq_o` is high only for requests at a strictly higher-priority slot. Requests at the same or a lower level are held off.
- R6: A write of any data to the vector-address register releases the most recently recorded level. Nested levels are released in reverse order. A write with nothing recorded has no effect.
- R7: A write to the software-set register ORs its data into the software requests. A write to the software-clear register clears each software bit where the data has a 1 and leaves all others. The block never clears a hardware request, so a source that is still asserted raises `irq_o` again after its acknowledge.
- R8: A source whose fast-select bit is 1 takes no part in normal arbitration and never appears in the vector address.
- R9: After reset, enables, fast selects, software requests, slot enables, slot and default addresses and the level record are all zero. Both outputs are low, and the vector-address register reads the default handler address (0).
- R10: Word addresses are: 0 enable, 1 fast select, 2 software set (reads the software requests), 3 software clear (reads 0), 4 vector address, 5 default address, 8+i slot i handler address, 16+i slot i control, with bits [4:0] the source number and bit 5 the slot enable. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 32 | Level-sensitive hardware request lines |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; vector reads have a side effect |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| fiq_o | output | 1 | Fast-interrupt request |
| irq_o | output | 1 | Normal-interrupt request |

## Verification
The hardest state to reach is a nest two levels deep, with a lower-priority request held off behind a recorded level while the served source keeps its line asserted. The bench reaches it by holding a slot-2 source high and reading its vector. It then raises a default-level source, which must stay held off, and then a slot-1 source, which must preempt and be read in turn. It then acknowledges one level at a time while the hardware lines remain asserted. In the same way, a default-level read followed by further default requests shows that the flat default level blocks itself but not the slots.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BUS_AW = 5;
  localparam logic [BUS_AW-1:0] A_ENABLE = 5'd0;
  localparam logic [BUS_AW-1:0] A_FAST   = 5'd1;
  localparam logic [BUS_AW-1:0] A_SWSET  = 5'd2;
  localparam logic [BUS_AW-1:0] A_SWCLR  = 5'd3;
  localparam logic [BUS_AW-1:0] A_VECT   = 5'd4;
  localparam logic [BUS_AW-1:0] A_DFLT   = 5'd5;
  localparam int unsigned SLOT_ADDR_BASE = 8;
  localparam int unsigned SLOT_CTL_BASE  = 16;
endpackage

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int unsigned NLVL  = 9,
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [NLVL-1:0]  allow
);
  logic [NLVL-1:0] svc_q;
  logic [NLVL-1:0] svc_after_pop;

  // Levels strictly more urgent than the most urgent recorded one are allowed
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < int'(NLVL); i++) begin
      seen     = seen | svc_q[i];
      allow[i] = ~seen;
    end
  end

  // The most recent entry is always the lowest set bit, so pop clears it
  assign svc_after_pop = pop ? (svc_q & (svc_q - NLVL'(1))) : svc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= '0;
    end else begin
      svc_q <= svc_after_pop | (push ? (NLVL'(1) << push_lvl) : '0);
    end
  end

  // R5: a new level may only be recorded above the current one
  a_r5_push_above_top: assert property (@(posedge clk) disable iff (rst)
    push |-> allow[push_lvl]);

  a_r5_push_adds_entry: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> ($countones(svc_q) == $past($countones(svc_q)) + 1));

  // R6: an acknowledge removes exactly one recorded level
  a_r6_pop_removes_one: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && (svc_q != '0)) |=> ($countones(svc_q) + 1 == $past($countones(svc_q))));
endmodule

// File: rtl/irq_slot_arbiter.sv
module irq_slot_arbiter #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 8,
  parameter int unsigned SRC_W = 5,
  parameter int unsigned LVL_W = 4
) (
  input  logic [NSRC-1:0]             pend_n,
  input  logic [NSLOT-1:0][SRC_W-1:0] slot_src,
  input  logic [NSLOT-1:0]            slot_en,
  input  logic [NSLOT:0]              allow,
  output logic [NSLOT:0]              lvl_req,
  output logic                        win_valid,
  output logic [LVL_W-1:0]            win_lvl
);
  logic [NSLOT-1:0][NSRC-1:0] claim;
  logic [NSRC-1:0]            claimed;

  for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
    assign lvl_req[s] = slot_en[s] & pend_n[slot_src[s]];
    assign claim[s]   = slot_en[s] ? (NSRC'(1) << slot_src[s]) : '0;
  end

  always_comb begin
    claimed = '0;
    for (int s = 0; s < int'(NSLOT); s++) claimed = claimed | claim[s];
  end

  assign lvl_req[NSLOT] = |(pend_n & ~claimed);

  always_comb begin
    win_valid = 1'b0;
    win_lvl   = LVL_W'(NSLOT);
    for (int l = int'(NSLOT); l >= 0; l--) begin
      if (lvl_req[l] && allow[l]) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 8,
  parameter int unsigned DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   hw_req,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned SRC_W = $clog2(NSRC);
  localparam int unsigned NLVL  = NSLOT + 1;
  localparam int unsigned LVL_W = $clog2(NLVL);

  logic [NSRC-1:0]             en_q, fast_q, sw_q;
  logic [DW-1:0]               dflt_q;
  logic [NSLOT-1:0][DW-1:0]    saddr_q;
  logic [NSLOT-1:0][SRC_W-1:0] ssrc_q;
  logic [NSLOT-1:0]            sen_q;

  logic [NSRC-1:0]  pend_raw, pend_n;
  logic [NLVL-1:0]  allow, lvl_req;
  logic             win_valid;
  logic [LVL_W-1:0] win_lvl;
  logic [DW-1:0]    vector;
  logic             vec_rd, vec_wr;

  assign pend_raw = (hw_req | sw_q) & en_q;
  assign pend_n   = pend_raw & ~fast_q;
  assign fiq_o    = |(pend_raw & fast_q);
  assign irq_o    = win_valid;

  assign vec_rd = bus_re && (bus_addr == A_VECT);
  assign vec_wr = bus_we && (bus_addr == A_VECT);

  irq_slot_arbiter #(.NSRC(NSRC), .NSLOT(NSLOT), .SRC_W(SRC_W), .LVL_W(LVL_W)) i_arb (
    .pend_n(pend_n), .slot_src(ssrc_q), .slot_en(sen_q), .allow(allow),
    .lvl_req(lvl_req), .win_valid(win_valid), .win_lvl(win_lvl)
  );

  irq_level_stack #(.NLVL(NLVL), .LVL_W(LVL_W)) i_stack (
    .clk(clk), .rst(rst), .push(vec_rd && win_valid), .push_lvl(win_lvl),
    .pop(vec_wr), .allow(allow)
  );

  always_comb begin
    vector = dflt_q;
    for (int s = 0; s < int'(NSLOT); s++) begin
      if (win_valid && (win_lvl == LVL_W'(s))) vector = saddr_q[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; fast_q <= '0; sw_q <= '0; dflt_q <= '0;
      saddr_q <= '0; ssrc_q <= '0; sen_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_ENABLE: en_q   <= bus_wdata[NSRC-1:0];
        A_FAST:   fast_q <= bus_wdata[NSRC-1:0];
        A_SWSET:  sw_q   <= sw_q | bus_wdata[NSRC-1:0];
        A_SWCLR:  sw_q   <= sw_q & ~bus_wdata[NSRC-1:0];
        A_DFLT:   dflt_q <= bus_wdata;
        default: ;
      endcase
      for (int s = 0; s < int'(NSLOT); s++) begin
        if (bus_addr == BUS_AW'(SLOT_ADDR_BASE + s)) saddr_q[s] <= bus_wdata;
        if (bus_addr == BUS_AW'(SLOT_CTL_BASE + s)) begin
          ssrc_q[s] <= bus_wdata[SRC_W-1:0];
          sen_q[s]  <= bus_wdata[SRC_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_ENABLE: bus_rdata <= DW'(en_q);
        A_FAST:   bus_rdata <= DW'(fast_q);
        A_SWSET:  bus_rdata <= DW'(sw_q);
        A_VECT:   bus_rdata <= vector;
        A_DFLT:   bus_rdata <= dflt_q;
        default: ;
      endcase
      for (int s = 0; s < int'(NSLOT); s++) begin
        if (bus_addr == BUS_AW'(SLOT_ADDR_BASE + s)) bus_rdata <= saddr_q[s];
        if (bus_addr == BUS_AW'(SLOT_CTL_BASE + s)) bus_rdata <= DW'({sen_q[s], ssrc_q[s]});
      end
    end
  end

  // R7: a software-clear write leaves none of the cleared bits set
  a_r7_swclr_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SWCLR) |=> ((sw_q & $past(bus_wdata[NSRC-1:0])) == '0));

  // R3: the winner is a requesting level that the record allows
  a_r3_winner_allowed: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (lvl_req[win_lvl] && allow[win_lvl]));

  // R8: fast sources never make the normal line rise on their own
  a_r8_fast_excluded: assert property (@(posedge clk) disable iff (rst)
    (pend_raw != '0 && (pend_raw & ~fast_q) == '0) |-> !irq_o);
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] hw_req = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  int errors = 0;
  int checks = 0;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .hw_req(hw_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Table: hardware pattern, expected fast, normal, vector
  localparam logic [31:0] T_HW [NROW] = '{
    32'h0000_0000, 32'h8000_0000, 32'h0000_0020, 32'h0000_0208, 32'h0000_0080,
    32'h0000_0088, 32'h0010_0000, 32'h8000_0020, 32'hFFFF_FFFF, 32'h0000_1000};
  localparam logic [NROW-1:0] T_FIQ = 10'b0110000010;
  localparam logic [NROW-1:0] T_IRQ = 10'b0111111100;
  localparam logic [31:0] T_VEC [NROW] = '{
    32'hD0, 32'hD0, 32'h100, 32'h110, 32'hD0,
    32'h120, 32'hD0, 32'h100, 32'h100, 32'hD0};
  localparam string T_TAG [NROW] = '{
    "R2", "R8", "R3", "R3", "R4", "R4", "R4", "R1", "R1", "R2"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic bread(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
    #1;
  endtask

  task automatic set_hw(logic [31:0] v);
    @(negedge clk);
    hw_req = v;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk("R9 fiq", {31'b0, fiq_o}, 32'd0);
    chk("R9 irq", {31'b0, irq_o}, 32'd0);
    bread(5'd4, rd); chk("R9 vector", rd, 32'h0);
    bread(5'd0, rd); chk("R9 enable", rd, 32'h0);
    bread(5'd16, rd); chk("R9 slot ctl", rd, 32'h0);

    // Configuration; R10 map
    bwrite(5'd0, 32'hFFFF_EFFF);
    bwrite(5'd1, 32'h8000_0000);
    bwrite(5'd5, 32'hD0);
    bwrite(5'd8, 32'h100);  bwrite(5'd16, 32'h20 | 32'd5);
    bwrite(5'd9, 32'h110);  bwrite(5'd17, 32'h20 | 32'd9);
    bwrite(5'd10, 32'h120); bwrite(5'd18, 32'h20 | 32'd3);
    bwrite(5'd11, 32'h130); bwrite(5'd19, 32'd20);
    bread(5'd17, rd); chk("R10 slot ctl readback", rd, 32'h29);
    bread(5'd9, rd);  chk("R10 slot addr readback", rd, 32'h110);
    bread(5'd3, rd);  chk("R10 swclr reads zero", rd, 32'h0);
    bread(5'd30, rd); chk("R10 unmapped", rd, 32'h0);

    for (int i = 0; i < NROW; i++) begin
      set_hw(T_HW[i]);
      chk({T_TAG[i], " fiq"}, {31'b0, fiq_o}, {31'b0, T_FIQ[i]});
      chk({T_TAG[i], " irq"}, {31'b0, irq_o}, {31'b0, T_IRQ[i]});
      bread(5'd4, rd);
      chk({T_TAG[i], " vector"}, rd, T_VEC[i]);
      if (T_IRQ[i]) bwrite(5'd4, 32'h0);
    end
    set_hw(32'h0);

    // R5 / R6 nesting with hardware lines held
    set_hw(32'h0000_0008);
    bread(5'd4, rd); chk("R5 slot2 vector", rd, 32'h120);
    chk("R5 irq held after read", {31'b0, irq_o}, 32'd0);
    set_hw(32'h0000_0088);
    chk("R5 default held off", {31'b0, irq_o}, 32'd0);
    set_hw(32'h0000_0288);
    chk("R5 slot1 preempts", {31'b0, irq_o}, 32'd1);
    bread(5'd4, rd); chk("R5 slot1 vector", rd, 32'h110);
    chk("R5 irq after nested read", {31'b0, irq_o}, 32'd0);
    bwrite(5'd4, 32'h1234);
    chk("R7 held line reasserts", {31'b0, irq_o}, 32'd1);
    set_hw(32'h0000_0088);
    chk("R6 inner level still held", {31'b0, irq_o}, 32'd0);
    bwrite(5'd4, 32'h0);
    chk("R6 outer release", {31'b0, irq_o}, 32'd1);
    bread(5'd4, rd); chk("R6 vector after release", rd, 32'h120);
    bwrite(5'd4, 32'h0);
    set_hw(32'h0);
    bwrite(5'd4, 32'h0);
    chk("R6 empty ack no effect", {31'b0, irq_o}, 32'd0);

    // Default level blocks itself, not slots
    set_hw(32'h0000_0080);
    bread(5'd4, rd); chk("R4 default vector", rd, 32'hD0);
    set_hw(32'h0010_0080);
    chk("R5 default blocks default", {31'b0, irq_o}, 32'd0);
    set_hw(32'h0010_00A0);
    chk("R5 slot beats default level", {31'b0, irq_o}, 32'd1);
    bread(5'd4, rd); chk("R5 slot0 vector", rd, 32'h100);
    bwrite(5'd4, 32'h0);
    bwrite(5'd4, 32'h0);
    set_hw(32'h0);

    // R7 software requests
    bwrite(5'd2, 32'h0000_0020);
    chk("R7 soft set raises irq", {31'b0, irq_o}, 32'd1);
    bread(5'd4, rd); chk("R7 soft vector", rd, 32'h100);
    bwrite(5'd4, 32'h0);
    chk("R7 soft persists after ack", {31'b0, irq_o}, 32'd1);
    bwrite(5'd3, 32'h0000_0020);
    chk("R7 soft clear drops irq", {31'b0, irq_o}, 32'd0);
    bwrite(5'd2, 32'h0000_0280);
    bwrite(5'd3, 32'h0000_0200);
    bread(5'd2, rd); chk("R7 selective clear", rd, 32'h0000_0080);
    bwrite(5'd3, 32'hFFFF_FFFF);
    bwrite(5'd2, 32'h0000_1000);
    chk("R2 disabled soft ignored", {31'b0, irq_o}, 32'd0);
    bwrite(5'd2, 32'h8000_0000);
    chk("R1 soft fast request", {31'b0, fiq_o}, 32'd1);
    chk("R8 soft fast not normal", {31'b0, irq_o}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule